// File: doc/BRIEF.md
# Oversampled serial slave front end with pause

This block sits between four slow serial pins and a command decoder running on a fast system clock. It samples chip select, serial clock, serial data and an active-low pause pin through synchronisers, then finds the serial clock edges inside the system clock domain. Each incoming byte goes to the decoder as a parallel word with a one-cycle strobe. Each reply byte is taken from the decoder and shifted back out, most significant bit first.

A frame runs from a chip-select fall to the next chip-select rise, and each boundary gets its own pulse. The end pulse comes with a flag that says whether the frame ended on a byte boundary. The pause pin can freeze a frame part-way through a byte. While it is frozen, the output driver turns off and clock or data activity is discarded. When it is released, the frame carries on at the same bit. Entering or leaving the pause is only accepted while the serial clock is low, so a change made during a high clock phase waits for the next low phase.

Top module: `spih_slave`

## Requirements
- R1: On each rising serial clock edge of an active, unpaused frame, the data pin is shifted in MSB first. After every 8th such edge, `rx_valid` pulses for one cycle and `rx_byte` holds the 8 captured bits.
- R2: `miso` changes only on falling serial clock edges that follow a rising edge, and sends MSB first. The first bit of each byte is bit 7 of `tx_byte`, loaded at the chip-select fall for the first byte and at the falling edge after a byte's 8th rising edge for each later byte.
- R3: Frames work both with the serial clock idling low (mode 0) and idling high (mode 3). In mode 3, the falling edge that comes before the first rising edge does not advance the output.
- R4: A chip-select fall produces a one-cycle `frame_start` and clears the bit position, so a partial byte left over from the previous frame does not affect the new one.
- R5: While chip select is high, `miso_oe` is 0, and serial clock and data activity produce no `rx_valid`.
- R6: When `pause_n` goes low while the serial clock is low, the frame is paused: `miso_oe` goes to 0, and serial clock edges and data changes are ignored.
- R7: When `pause_n` returns high while the serial clock is low, `miso_oe` returns to 1 and the frame resumes at the exact bit where it stopped, in both directions.
- R8: A change of `pause_n` made while the serial clock is high takes effect only once the serial clock is low again. A falling edge that ends that high phase is still processed with the old pause state.
- R9: A chip-select rise produces a one-cycle `frame_end`. Alongside it, `frame_whole` is 1 exactly when the number of bits captured in the frame is a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select pin |
| sclk | input | 1 | Serial clock pin |
| mosi | input | 1 | Serial data into the block |
| pause_n | input | 1 | Active-low pause pin |
| tx_byte | input | BYTE_W | Reply byte from the decoder |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for the serial data driver |
| rx_valid | output | 1 | One-cycle strobe marking a completed byte |
| rx_byte | output | BYTE_W | Last completed received byte |
| frame_start | output | 1 | One-cycle pulse on chip-select fall |
| frame_end | output | 1 | One-cycle pulse on chip-select rise |
| frame_whole | output | 1 | Valid with frame_end: frame ended on a byte boundary |

## Verification
Random frames of one to three bytes are run in both clock polarities, with random data in both directions. This separates mode 0 from mode 3 and catches errors in byte-boundary reloads of the reply. Some frames are paused during a low clock phase while clock pulses and data changes are injected. These show whether the pause really discards edges and whether the resume lands on the same bit. Other frames change the pause pin during a high clock phase, which tells an immediate pause apart from a deferred one. Directed cases cover a frame cut off after 13 bits, followed by a full frame that checks the bit position was reset, and clock activity while chip select is high.

// File: rtl/spih_pkg.sv
`timescale 1ns/1ps
package spih_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } spih_edge_t;

  localparam int SPIH_SYNC_DEF = 2;
endpackage

// File: rtl/spih_sync.sv
`timescale 1ns/1ps
module spih_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spih_edge.sv
`timescale 1ns/1ps
module spih_edge
  import spih_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  output spih_edge_t ev
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= din;
  end

  assign ev.rise = din & ~prev;
  assign ev.fall = ~din & prev;
endmodule

// File: rtl/spih_shift.sv
`timescale 1ns/1ps
module spih_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              paused,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              din,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              dout,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              frame_start,
  output logic              frame_end,
  output logic              frame_whole
);
  localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     bit_pos;
  logic              armed;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next = {rx_sh[BYTE_W-2:0], din};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_pos     <= '0;
      armed       <= 1'b0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      rx_valid    <= 1'b0;
      rx_byte     <= '0;
      frame_start <= 1'b0;
      frame_end   <= 1'b0;
      frame_whole <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      frame_start <= cs_fall;
      frame_end   <= cs_rise;
      if (cs_rise) frame_whole <= (bit_pos == '0);
      if (cs_fall) begin
        bit_pos <= '0;
        armed   <= 1'b0;
        tx_sh   <= tx_byte;
      end else if (active && !paused) begin
        if (sck_rise) begin
          rx_sh <= rx_next;
          armed <= 1'b1;
          if (bit_pos == LAST) begin
            bit_pos  <= '0;
            rx_valid <= 1'b1;
            rx_byte  <= rx_next;
          end else begin
            bit_pos <= bit_pos + 1'b1;
          end
        end else if (sck_fall && armed) begin
          armed <= 1'b0;
          if (bit_pos == '0) tx_sh <= tx_byte;
          else               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign dout = tx_sh[BYTE_W-1];

  AST_HALT_WHEN_PAUSED: assert property (@(posedge clk) disable iff (rst)
    (paused && !cs_fall) |=> $stable(bit_pos)); // R6

  AST_NO_BYTE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active |=> !rx_valid); // R5

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start); // R4

  AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end); // R9
endmodule

// File: rtl/spih_slave.sv
`timescale 1ns/1ps
module spih_slave
  import spih_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = SPIH_SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              pause_n,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              miso,
  output logic              miso_oe,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              frame_start,
  output logic              frame_end,
  output logic              frame_whole
);
  localparam logic [3:0] PIN_RST = 4'b1001;

  logic [3:0] pins_s;
  logic       cs_s, sck_s, din_s, pz_s;
  spih_edge_t cs_ev, sck_ev;
  logic       paused;

  spih_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, sclk, mosi, pause_n}),
    .q(pins_s)
  );

  assign {cs_s, sck_s, din_s, pz_s} = pins_s;

  spih_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst(rst), .din(cs_s), .ev(cs_ev)
  );

  spih_edge #(.RST_VAL(1'b0)) u_sck_edge (
    .clk(clk), .rst(rst), .din(sck_s), .ev(sck_ev)
  );

  // Pause state may only move while the synchronised clock is low.
  always_ff @(posedge clk) begin
    if (rst) begin
      paused  <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      if (!sck_s) paused <= ~pz_s;
      miso_oe <= ~cs_s & ~paused;
    end
  end

  spih_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst),
    .active(~cs_s), .paused(paused),
    .cs_fall(cs_ev.rise == 1'b0 && cs_ev.fall),
    .cs_rise(cs_ev.rise),
    .sck_rise(sck_ev.rise), .sck_fall(sck_ev.fall),
    .din(din_s), .tx_byte(tx_byte),
    .dout(miso), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .frame_start(frame_start), .frame_end(frame_end),
    .frame_whole(frame_whole)
  );

  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s)) |=> !miso_oe); // R5

  AST_PAUSE_DEFERRED: assert property (@(posedge clk) disable iff (rst)
    sck_s |=> $stable(paused)); // R8

  AST_OE_OFF_PAUSED: assert property (@(posedge clk) disable iff (rst)
    (paused && $past(paused)) |=> !miso_oe); // R6
endmodule

// File: tb/spih_slave_test.sv
`timescale 1ns/1ps
module spih_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, pause_n = 1'b1;
  logic [7:0] tx_byte = 8'h00;
  logic       miso, miso_oe, rx_valid, frame_start, frame_end, frame_whole;
  logic [7:0] rx_byte;

  int n_chk = 0, n_fail = 0;
  int rxn = 0, fs_n = 0, fe_n = 0;
  logic [7:0] rxlog [256];
  logic last_whole = 1'b0;
  logic [7:0] mdata [8];
  logic [7:0] rdata [9];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spih_slave uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .pause_n(pause_n), .tx_byte(tx_byte), .miso(miso), .miso_oe(miso_oe),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .frame_start(frame_start),
    .frame_end(frame_end), .frame_whole(frame_whole)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        rxlog[rxn % 256] = rx_byte;
        rxn++;
      end
      if (frame_start) fs_n++;
      if (frame_end) begin
        fe_n++;
        last_whole = frame_whole;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic bit exp_whole(input int nbits);
    return (nbits % 8) == 0;
  endfunction

  // hkind: 0 none, 1 pause during low phase, 2 pause pin moved during high phase
  task automatic xfer(input bit m3, input int nbits, input int hkind, input int hbit);
    int rx0 = rxn;
    int fs0 = fs_n;
    int fe0 = fe_n;
    int r;
    logic [7:0] got = 8'h00;
    bit pend = 0;
    sclk = m3; tx_byte = rdata[0]; tick(H);
    cs_n = 1'b0; tick(H);
    chk(fs_n == fs0 + 1, "R4 frame_start", fs_n - fs0, 1);
    chk(miso_oe == 1'b1, "R3 oe in frame", miso_oe, 1);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; tick(H);
      if (pend) begin
        pend = 0;
        chk(miso_oe == 1'b0, "R8 pause applied after low", miso_oe, 0);
        sclk = 1'b1; tick(H);
        pause_n = 1'b1; tick(H);
        chk(miso_oe == 1'b0, "R8 release deferred while high", miso_oe, 0);
        sclk = 1'b0; tick(H);
        chk(miso_oe == 1'b1, "R7 resume after low", miso_oe, 1);
      end
      if (hkind == 1 && i == hbit) begin
        pause_n = 1'b0; tick(H);
        chk(miso_oe == 1'b0, "R6 oe off paused", miso_oe, 0);
        r = rxn;
        for (int k = 0; k < 9; k++) begin
          mosi = ~mosi; sclk = 1'b1; tick(H);
          sclk = 1'b0; tick(H);
        end
        chk(rxn == r, "R6 edges ignored", rxn - r, 0);
        pause_n = 1'b1; tick(H);
        chk(miso_oe == 1'b1, "R7 oe back", miso_oe, 1);
      end
      mosi = mdata[i/8][7 - (i % 8)]; tick(H);
      got = {got[6:0], miso};
      sclk = 1'b1; tick(H);
      if (i % 8 == 7) begin
        chk(got == rdata[i/8], m3 ? "R2 R3 reply byte mode3" : "R2 reply byte mode0",
            got, rdata[i/8]);
        tx_byte = rdata[i/8 + 1];
      end
      if (hkind == 2 && i == hbit) begin
        pause_n = 1'b0; tick(H);
        chk(miso_oe == 1'b1, "R8 entry deferred while high", miso_oe, 1);
        pend = 1;
      end
    end
    if (!m3) begin sclk = 1'b0; tick(H); end
    cs_n = 1'b1; tick(2*H);
    chk(miso_oe == 1'b0, "R5 oe off deselected", miso_oe, 0);
    chk(fe_n == fe0 + 1, "R9 frame_end", fe_n - fe0, 1);
    chk(last_whole == exp_whole(nbits), "R9 frame_whole", last_whole, exp_whole(nbits));
    chk(rxn - rx0 == nbits / 8, "R1 byte count", rxn - rx0, nbits / 8);
    for (int k = 0; k < nbits / 8; k++)
      chk(rxlog[(rx0 + k) % 256] == mdata[k], m3 ? "R1 R3 rx mode3" : "R1 rx mode0",
          rxlog[(rx0 + k) % 256], mdata[k]);
  endtask

  task automatic fill(input int nb);
    for (int k = 0; k < 9; k++) rdata[k] = 8'($urandom);
    for (int k = 0; k < 8; k++) mdata[k] = 8'($urandom);
    if (nb > 0) begin mdata[0] = 8'h81; rdata[0] = 8'hA5; end
  endtask

  initial begin
    int r, seed;
    seed = $urandom(32'd7);
    tick(5);
    rst = 1'b0;
    tick(4);
    chk(miso_oe == 1'b0, "R5 reset oe", miso_oe, 0);
    chk(rx_valid == 1'b0, "R1 reset valid", rx_valid, 0);
    chk(frame_end == 1'b0 && frame_start == 1'b0, "R9 reset pulses", frame_end, 0);

    // directed: both modes, no pause
    fill(1); xfer(1'b0, 16, 0, 0);
    fill(1); xfer(1'b1, 16, 0, 0);
    // directed: pause in low phase, at byte start and mid byte
    fill(1); xfer(1'b0, 16, 1, 8);
    fill(1); xfer(1'b1, 24, 1, 3);
    // directed: pause pin moved while clock high
    fill(1); xfer(1'b0, 16, 2, 4);
    fill(1); xfer(1'b1, 16, 2, 7);
    // directed: cut frame, then full frame checks bit position reset
    fill(1); xfer(1'b0, 13, 0, 0);
    fill(1); xfer(1'b0, 8, 0, 0);
    // directed: clock activity while deselected
    r = rxn;
    for (int k = 0; k < 20; k++) begin
      mosi = ~mosi; sclk = ~sclk; tick(H);
      chk(miso_oe == 1'b0, "R5 oe idle", miso_oe, 0);
    end
    sclk = 1'b0; tick(H);
    chk(rxn == r, "R5 no bytes while deselected", rxn - r, 0);

    // random frames
    for (int f = 0; f < 14; f++) begin
      int nb = 1 + int'($urandom % 3);
      int hk = int'($urandom % 3);
      int hb = int'($urandom % (nb*8 - 1));
      fill(0);
      xfer(1'($urandom % 2), nb * 8, hk, hb);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule